// File: doc/BRIEF.md
# Register File with Partial-Width Access

This block holds eight 32-bit general registers with one write port and two independent read ports. Every port carries a register index and a two-bit part select, so software-visible registers can be touched as a whole word, as the low 16-bit half, or, on the first four registers only, as either byte of that low half. A narrow write merges its bits into the stored word and leaves every other bit alone. A narrow read comes back right-aligned and zero-extended to 32 bits.

Reads are combinational from the stored state. Writes take effect on the rising clock edge. The last four registers have no byte view. A byte request aimed at one of them is rejected: a write is dropped and flagged, and a read returns zero and is flagged.

Part select encoding, shared by all ports: 0 = full word (bits 31:0), 1 = low half (bits 15:0), 2 = low byte (bits 7:0), 3 = second byte of the low half (bits 15:8).

Top module: `gpr_file`

## Requirements
- R1: An active-low reset clears all eight registers to zero.
- R2: A write with part 0 replaces all 32 bits of the indexed register with wrData, and a part-0 read returns the full stored word.
- R3: A write with part 1 loads bits 15:0 from wrData[15:0] and keeps bits 31:16.
- R4: On registers 0 to 3, a part-2 write loads bits 7:0 from wrData[7:0], and a part-3 write loads bits 15:8 from wrData[7:0]. All other bits are kept in both cases.
- R5: A part-2 or part-3 write to registers 4 to 7 raises wrIllegal in the same cycle and changes no register.
- R6: Narrow reads are zero-extended. Part 1 returns {16'h0, bits 15:0}, part 2 returns {24'h0, bits 7:0}, and part 3 returns {24'h0, bits 15:8}.
- R7: A part-2 or part-3 read of registers 4 to 7 raises that port's illegal flag and returns zero.
- R8: A read of the register being written in the same cycle returns the value held before the write. The new value is visible after the clock edge.
- R9: The two read ports work independently and may address the same register or different registers, with any part each.
- R10: A write changes no register other than the one it indexes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrIdx | input | 3 | Register written |
| wrPart | input | 2 | Part select for the write |
| wrData | input | 32 | Write data, right-aligned for narrow parts |
| wrIllegal | output | 1 | Byte write to a register without byte access |
| rdIdxA | input | 3 | Register read on port A |
| rdPartA | input | 2 | Part select for port A |
| rdDataA | output | 32 | Port A data, zero-extended |
| rdIllegalA | output | 1 | Port A byte read of a register without byte access |
| rdIdxB | input | 3 | Register read on port B |
| rdPartB | input | 2 | Part select for port B |
| rdDataB | output | 32 | Port B data, zero-extended |
| rdIllegalB | output | 1 | Port B byte read of a register without byte access |

## Verification
A directed chain of full, half, low-byte and high-byte writes lands on one register with distinct bytes, so each merge shows exactly which lanes moved and which were kept. Byte writes and reads on registers 4 to 7 show whether rejection is tied to the index boundary. A write whose target is also read in the same cycle separates pre-edge from post-edge visibility. Several thousand random cycles then mix every part, index, write enable and port pairing against a reference array. This exposes lane-mask, shift and index-decode errors that the directed values alone could miss.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [1:0] {
    PART_FULL  = 2'd0,
    PART_HALF  = 2'd1,
    PART_BYTE0 = 2'd2,
    PART_BYTE1 = 2'd3
  } part_e;

  // Write strobes: which lane groups load, and whether the byte is moved up
  typedef struct packed {
    logic wrOn;
    logic laneUp;
    logic lane1;
    logic lane0;
    logic shiftUp;
  } wr_strobe_t;

  // Read strobes: which lane groups pass, and whether the result moves down
  typedef struct packed {
    logic laneUp;
    logic lane1;
    logic lane0;
    logic shiftDown;
  } rd_strobe_t;

endpackage

// File: rtl/gpr_ctrl.sv
module gpr_ctrl
  import rf_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  parameter int RD_PORTS  = 2,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [IDX_W-1:0]                  wrIdx,
  input  logic [1:0]                        wrPart,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]    rdIdx,
  input  logic [RD_PORTS-1:0][1:0]          rdPart,
  output wr_strobe_t                        wrStb,
  output logic                              wrIllegal,
  output rd_strobe_t [RD_PORTS-1:0]         rdStb,
  output logic [RD_PORTS-1:0]               rdIllegal
);

  function automatic logic isByte(input part_e p);
    return (p == PART_BYTE0) || (p == PART_BYTE1);
  endfunction

  function automatic logic byteOk(input logic [IDX_W-1:0] idx);
    return int'(idx) < BYTE_REGS;
  endfunction

  part_e wrKind;
  logic  wrBad;

  always_comb begin
    wrKind        = part_e'(wrPart);
    wrBad         = isByte(wrKind) && !byteOk(wrIdx);
    wrIllegal     = wrEn && wrBad;
    wrStb.wrOn    = wrEn && !wrBad;
    wrStb.laneUp  = (wrKind == PART_FULL);
    wrStb.lane1   = (wrKind == PART_FULL) || (wrKind == PART_HALF) || (wrKind == PART_BYTE1);
    wrStb.lane0   = (wrKind == PART_FULL) || (wrKind == PART_HALF) || (wrKind == PART_BYTE0);
    wrStb.shiftUp = (wrKind == PART_BYTE1);
  end

  genvar p;
  generate
    for (p = 0; p < RD_PORTS; p++) begin : g_rd
      part_e rdKind;
      logic  rdBad;

      always_comb begin
        rdKind              = part_e'(rdPart[p]);
        rdBad               = isByte(rdKind) && !byteOk(rdIdx[p]);
        rdIllegal[p]        = rdBad;
        rdStb[p].laneUp     = !rdBad && (rdKind == PART_FULL);
        rdStb[p].lane1      = !rdBad && ((rdKind == PART_FULL) || (rdKind == PART_HALF) ||
                                         (rdKind == PART_BYTE1));
        rdStb[p].lane0      = !rdBad && ((rdKind == PART_FULL) || (rdKind == PART_HALF) ||
                                         (rdKind == PART_BYTE0));
        rdStb[p].shiftDown  = !rdBad && (rdKind == PART_BYTE1);
      end

      AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
        rdIllegal[p] |-> !(rdStb[p].laneUp || rdStb[p].lane1 || rdStb[p].lane0)); // R7
    end
  endgenerate

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    wrIllegal |-> !wrStb.wrOn); // R5

  AST_BYTE_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.wrOn && wrStb.shiftUp) |-> (wrStb.lane1 && !wrStb.lane0 && !wrStb.laneUp)); // R4

endmodule

// File: rtl/gpr_dp.sv
module gpr_dp
  import rf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int NUM_REGS  = 8,
  parameter int RD_PORTS  = 2,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int HALF_W   = 2 * BYTE_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  wr_strobe_t                        wrStb,
  input  logic [IDX_W-1:0]                  wrIdx,
  input  logic [DATA_W-1:0]                 wrData,
  input  rd_strobe_t [RD_PORTS-1:0]         rdStb,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]    rdIdx,
  output logic [RD_PORTS-1:0][DATA_W-1:0]   rdData
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] oldVal;
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] merged;

  // Merge the aligned write data into the current word, lane group by lane group
  always_comb begin
    oldVal  = regs[wrIdx];
    aligned = wrStb.shiftUp ? (wrData << BYTE_W) : wrData;
    merged  = oldVal;
    if (wrStb.laneUp) merged[DATA_W-1:HALF_W] = aligned[DATA_W-1:HALF_W];
    if (wrStb.lane1)  merged[HALF_W-1:BYTE_W] = aligned[HALF_W-1:BYTE_W];
    if (wrStb.lane0)  merged[BYTE_W-1:0]      = aligned[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wrStb.wrOn) begin
      regs[wrIdx] <= merged;
    end
  end

  genvar p, r;
  generate
    for (p = 0; p < RD_PORTS; p++) begin : g_rd
      logic [DATA_W-1:0] raw;
      logic [DATA_W-1:0] masked;

      always_comb begin
        raw    = regs[rdIdx[p]];
        masked = '0;
        if (rdStb[p].laneUp) masked[DATA_W-1:HALF_W] = raw[DATA_W-1:HALF_W];
        if (rdStb[p].lane1)  masked[HALF_W-1:BYTE_W] = raw[HALF_W-1:BYTE_W];
        if (rdStb[p].lane0)  masked[BYTE_W-1:0]      = raw[BYTE_W-1:0];
        rdData[p] = rdStb[p].shiftDown ? (masked >> BYTE_W) : masked;
      end
    end

    for (r = 0; r < NUM_REGS; r++) begin : g_chk
      AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rstN)
        !(wrStb.wrOn && wrIdx == IDX_W'(r) && wrStb.laneUp)
          |=> $stable(regs[r][DATA_W-1:HALF_W])); // R3
      AST_HIBYTE_HELD: assert property (@(posedge clk) disable iff (!rstN)
        !(wrStb.wrOn && wrIdx == IDX_W'(r) && wrStb.lane1)
          |=> $stable(regs[r][HALF_W-1:BYTE_W])); // R4
      AST_LOBYTE_HELD: assert property (@(posedge clk) disable iff (!rstN)
        !(wrStb.wrOn && wrIdx == IDX_W'(r) && wrStb.lane0)
          |=> $stable(regs[r][BYTE_W-1:0])); // R10
    end
  endgenerate

endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import rf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int HALF_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrPart,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrIllegal,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [1:0]        rdPartA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdIllegalA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [1:0]        rdPartB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdIllegalB
);

  localparam int RD_PORTS = 2;

  wr_strobe_t                        wrStb;
  rd_strobe_t [RD_PORTS-1:0]         rdStb;
  logic [RD_PORTS-1:0][IDX_W-1:0]    rdIdx;
  logic [RD_PORTS-1:0][1:0]          rdPart;
  logic [RD_PORTS-1:0][DATA_W-1:0]   rdData;
  logic [RD_PORTS-1:0]               rdIllegal;

  assign rdIdx      = {rdIdxB, rdIdxA};
  assign rdPart     = {rdPartB, rdPartA};
  assign rdDataA    = rdData[0];
  assign rdDataB    = rdData[1];
  assign rdIllegalA = rdIllegal[0];
  assign rdIllegalB = rdIllegal[1];

  gpr_ctrl #(
    .NUM_REGS (NUM_REGS),
    .BYTE_REGS(BYTE_REGS),
    .RD_PORTS (RD_PORTS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrPart   (wrPart),
    .rdIdx    (rdIdx),
    .rdPart   (rdPart),
    .wrStb    (wrStb),
    .wrIllegal(wrIllegal),
    .rdStb    (rdStb),
    .rdIllegal(rdIllegal)
  );

  gpr_dp #(
    .DATA_W  (DATA_W),
    .BYTE_W  (BYTE_W),
    .NUM_REGS(NUM_REGS),
    .RD_PORTS(RD_PORTS)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrStb (wrStb),
    .wrIdx (wrIdx),
    .wrData(wrData),
    .rdStb (rdStb),
    .rdIdx (rdIdx),
    .rdData(rdData)
  );

  AST_RD_ZEXT_A: assert property (@(posedge clk) disable iff (!rstN)
    (rdPartA != 2'd0) |-> (rdDataA[DATA_W-1:HALF_W] == '0)); // R6
  AST_RD_ZEXT_B: assert property (@(posedge clk) disable iff (!rstN)
    (rdPartB != 2'd0) |-> (rdDataB[DATA_W-1:HALF_W] == '0)); // R6
  AST_RD_ILLEGAL_ZERO_A: assert property (@(posedge clk) disable iff (!rstN)
    rdIllegalA |-> (rdDataA == '0)); // R7
  AST_RD_ILLEGAL_ZERO_B: assert property (@(posedge clk) disable iff (!rstN)
    rdIllegalB |-> (rdDataB == '0)); // R7
  AST_WR_ILLEGAL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrIllegal |-> (wrEn && int'(wrIdx) >= BYTE_REGS && wrPart[1])); // R5

endmodule

// File: tb/gpr_file_tb_top.sv
module gpr_file_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [1:0]  wrPart = '0;
  logic [31:0] wrData = '0;
  logic        wrIllegal;
  logic [2:0]  rdIdxA = '0;
  logic [1:0]  rdPartA = '0;
  logic [31:0] rdDataA;
  logic        rdIllegalA;
  logic [2:0]  rdIdxB = '0;
  logic [1:0]  rdPartB = '0;
  logic [31:0] rdDataB;
  logic        rdIllegalB;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] refRegs [8];
  logic [31:0] lastA, lastB;
  logic        lastWrIll;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_file dut_i (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrPart(wrPart), .wrData(wrData), .wrIllegal(wrIllegal),
    .rdIdxA(rdIdxA), .rdPartA(rdPartA), .rdDataA(rdDataA), .rdIllegalA(rdIllegalA),
    .rdIdxB(rdIdxB), .rdPartB(rdPartB), .rdDataB(rdDataB), .rdIllegalB(rdIllegalB)
  );

  function automatic logic legal(input logic [2:0] idx, input logic [1:0] part);
    return (part < 2'd2) || (idx < 3'd4);
  endfunction

  function automatic logic [31:0] mergeRef(input logic [31:0] old, input logic [1:0] part,
                                           input logic [31:0] d);
    case (part)
      2'd0:    return d;
      2'd1:    return {old[31:16], d[15:0]};
      2'd2:    return {old[31:8], d[7:0]};
      default: return {old[31:16], d[7:0], old[7:0]};
    endcase
  endfunction

  function automatic logic [31:0] readRef(input logic [31:0] v, input logic [1:0] part);
    case (part)
      2'd0:    return v;
      2'd1:    return {16'h0, v[15:0]};
      2'd2:    return {24'h0, v[7:0]};
      default: return {24'h0, v[15:8]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tagFor(input logic we, input logic [2:0] wi,
                                   input logic [2:0] ri, input logic [1:0] rp);
    if (!legal(ri, rp))       return "R7";
    if (we && wi == ri)       return "R8";
    if (rp == 2'd0)           return "R2";
    return "R6";
  endfunction

  // One clock: drive at falling edge, check reads before the rising edge, update model after it
  task automatic doCycle(input logic we, input logic [2:0] wi, input logic [1:0] wp,
                         input logic [31:0] wd, input logic [2:0] ria, input logic [1:0] rpa,
                         input logic [2:0] rib, input logic [1:0] rpb);
    logic [31:0] expA, expB;
    @(negedge clk);
    wrEn = we; wrIdx = wi; wrPart = wp; wrData = wd;
    rdIdxA = ria; rdPartA = rpa; rdIdxB = rib; rdPartB = rpb;
    #1;
    expA = legal(ria, rpa) ? readRef(refRegs[ria], rpa) : 32'h0;
    expB = legal(rib, rpb) ? readRef(refRegs[rib], rpb) : 32'h0;
    lastA = rdDataA; lastB = rdDataB; lastWrIll = wrIllegal;
    chk(tagFor(we, wi, ria, rpa), rdDataA, expA);
    chk("R9", rdDataB, expB);
    chk("R7", {31'h0, rdIllegalA}, {31'h0, !legal(ria, rpa)});
    chk("R7", {31'h0, rdIllegalB}, {31'h0, !legal(rib, rpb)});
    chk("R5", {31'h0, wrIllegal}, {31'h0, we && !legal(wi, wp)});
    @(posedge clk);
    if (we && legal(wi, wp)) refRegs[wi] = mergeRef(refRegs[wi], wp, wd);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) refRegs[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every register reads zero after reset
    for (int i = 0; i < 8; i++) begin
      doCycle(1'b0, 3'd0, 2'd0, 32'h0, 3'(i), 2'd0, 3'(i), 2'd1);
      chk("R1", lastA, 32'h0);
    end

    // R2/R3/R4: merge chain on register 0
    doCycle(1'b1, 3'd0, 2'd0, 32'hA1B2C3D4, 3'd1, 2'd0, 3'd2, 2'd0);
    doCycle(1'b0, 3'd0, 2'd0, 32'h0, 3'd0, 2'd0, 3'd0, 2'd3);
    chk("R2", lastA, 32'hA1B2C3D4);
    chk("R6", lastB, 32'h000000C3);
    doCycle(1'b1, 3'd0, 2'd1, 32'hFFFF1234, 3'd0, 2'd0, 3'd0, 2'd0);
    doCycle(1'b0, 3'd0, 2'd0, 32'h0, 3'd0, 2'd0, 3'd0, 2'd1);
    chk("R3", lastA, 32'hA1B21234);
    chk("R6", lastB, 32'h00001234);
    doCycle(1'b1, 3'd0, 2'd2, 32'hFFFFFF56, 3'd0, 2'd0, 3'd0, 2'd0);
    doCycle(1'b1, 3'd0, 2'd3, 32'hFFFFFF9A, 3'd0, 2'd0, 3'd0, 2'd0);
    doCycle(1'b0, 3'd0, 2'd0, 32'h0, 3'd0, 2'd0, 3'd0, 2'd2);
    chk("R4", lastA, 32'hA1B29A56);
    chk("R6", lastB, 32'h00000056);

    // R5: rejected byte write on register 5
    doCycle(1'b1, 3'd5, 2'd0, 32'hCAFEF00D, 3'd0, 2'd0, 3'd0, 2'd0);
    doCycle(1'b1, 3'd5, 2'd3, 32'h00000077, 3'd5, 2'd0, 3'd5, 2'd1);
    chk("R5", {31'h0, lastWrIll}, 32'h1);
    doCycle(1'b0, 3'd0, 2'd0, 32'h0, 3'd5, 2'd0, 3'd5, 2'd3);
    chk("R5", lastA, 32'hCAFEF00D);
    chk("R7", lastB, 32'h0);

    // R8: same-cycle read sees the old word, next cycle the new one
    doCycle(1'b1, 3'd0, 2'd0, 32'h11111111, 3'd0, 2'd0, 3'd0, 2'd2);
    chk("R8", lastA, 32'hA1B29A56);
    doCycle(1'b0, 3'd0, 2'd0, 32'h0, 3'd0, 2'd0, 3'd1, 2'd0);
    chk("R8", lastA, 32'h11111111);
    chk("R10", lastB, 32'h0);

    // Random mixed traffic against the reference array
    for (int n = 0; n < RAND_CYCLES; n++) begin
      logic we;
      logic [2:0] wi, ria, rib;
      logic [1:0] wp, rpa, rpb;
      we  = ($urandom % 4) != 0;
      wi  = 3'($urandom);
      wp  = 2'($urandom);
      ria = (($urandom % 4) == 0) ? wi : 3'($urandom);
      rib = 3'($urandom);
      rpa = 2'($urandom);
      rpb = 2'($urandom);
      doCycle(we, wi, wp, $urandom, ria, rpa, rib, rpb);
    end

    // R10: final sweep of all registers
    for (int i = 0; i < 8; i++) begin
      doCycle(1'b0, 3'd0, 2'd0, 32'h0, 3'(i), 2'd0, 3'(i), 2'd0);
      chk("R10", lastA, refRegs[i]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule